// File: doc/BRIEF.md
# JESD204 Transmit Transport Framer

This block sits between the sample sources of a multi-channel DAC transmit path and the link layer. Each beat it takes a fixed group of 16-bit, LSB-aligned samples from every converter channel and lays them onto the link lanes. Every lane carries four octets per beat.

Each sample is first cut to the converter resolution and widened to its slot width with zero tail bits. The slots are then grouped into frames, and a single beat can hold more than one frame. Finally the octets of each frame are dealt across the lanes.

The whole map is wiring only. Every kept input bit lands on exactly one output bit, and there are no gates, no registers and no clock. The valid and ready signals cross the block untouched. Samples per frame and octets per frame are not free parameters. The block derives the lowest-latency pair from the lane count, the converter count and the slot width, so an integrator sets only those three values and the resolution.

Top module: `jtx_transport_framer`

## Requirements
- R1: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle, for all four combinations.
- R2: The sample of channel m at time index k within the beat (k = 0 earliest) is read from `in_data[(m*SPB+k)*16 +: 16]`. SPB = S*4/F is the number of samples per channel per beat.
- R3: Only bits [RES_BITS-1:0] of each 16-bit input sample are used. Setting any bit above them leaves `out_data` unchanged.
- R4: Each sample becomes a SLOT_BITS-wide slot. The RES_BITS sample bits sit in the upper part of the slot, and the SLOT_BITS-RES_BITS tail bits at its least significant end are zero.
- R5: Let g = gcd(8*LANES, CONVS*SLOT_BITS). Then S = 8*LANES/g samples per frame and F = CONVS*SLOT_BITS/g octets per frame, and a beat holds 4/F frames. The legal values of F are 1, 2 and 4.
- R6: Frame f of a beat holds the samples with k = f*S+s, for s = 0..S-1. Inside the frame, slot q = m*S+s is the q-th slot sent, and each slot is sent MSB first.
- R7: Octet o of a frame (o = 0 first) goes to lane o/F. There it is octet f*F + o%F of the beat.
- R8: Beat octet w of lane l is `out_data[l*32+w*8 +: 8]`, and octet 0 is sent first. Bit 7 of each octet is its first bit on the link.
- R9: Every output bit is either a copy of one used input bit or a zero tail bit. No input bit is copied twice, and the output follows the input in the same cycle.
- R10: With one converter the single channel feeds the frames directly, and its slots fill each frame in time order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_valid | input | 1 | Sample group valid from the source |
| in_ready | output | 1 | Ready returned to the source (equals `out_ready`) |
| in_data | input | CONVS*SPB*16 | Per-channel LSB-aligned 16-bit samples for one beat |
| out_valid | output | 1 | Beat valid toward the link (equals `in_valid`) |
| out_ready | input | 1 | Ready from the link layer |
| out_data | output | LANES*32 | Lane words, four octets per lane |

## Verification
The hardest situation to reach from the ports is proof that no two input bits share one output bit, or reach it in swapped order. Random data can hide such an error when neighbouring bits happen to be equal. The stimulus therefore walks a single one through every input bit position of each configuration and compares the whole lane output with an independent reverse-mapping model. Configurations with several frames per beat, a single-lane case with four-octet frames, a one-converter 12-bit-slot case and nonzero tail widths are all built side by side. This puts each branch of the frame and lane arithmetic under test.

// File: rtl/jtx_pkg.sv
package jtx_pkg;

  localparam int unsigned SAMPLE_W    = 16;
  localparam int unsigned BEAT_OCTETS = 4;

  function automatic int unsigned gcd_u(input int unsigned a, input int unsigned b);
    int unsigned x;
    int unsigned y;
    int unsigned t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  // smallest samples-per-frame satisfying S/F = 8L/(M*NP)
  function automatic int unsigned frame_samples(input int unsigned l, input int unsigned m,
                                                input int unsigned np);
    return (8 * l) / gcd_u(8 * l, m * np);
  endfunction

  function automatic int unsigned frame_octets(input int unsigned l, input int unsigned m,
                                               input int unsigned np);
    return (m * np) / gcd_u(8 * l, m * np);
  endfunction

endpackage

// File: rtl/jtx_slot_pad.sv
module jtx_slot_pad
  import jtx_pkg::*;
#(
  parameter int unsigned RES_BITS  = 14,
  parameter int unsigned SLOT_BITS = 16
) (
  input  logic [SAMPLE_W-1:0]  samp_i,
  output logic [SLOT_BITS-1:0] slot_o
);

  localparam int unsigned TAIL_W = SLOT_BITS - RES_BITS;

  generate
    if (TAIL_W > 0) begin : g_tail
      assign slot_o = {samp_i[RES_BITS-1:0], {TAIL_W{1'b0}}};
    end else begin : g_notail
      assign slot_o = samp_i[RES_BITS-1:0];
    end

    if (RES_BITS < SAMPLE_W) begin : g_drop
      logic unused_hi;
      assign unused_hi = ^samp_i[SAMPLE_W-1:RES_BITS];
    end
  endgenerate

  // R4: the slot keeps exactly the resolution bits, nothing from above them
  always_comb begin
    if (!$isunknown(samp_i)) begin
      assert_slot_bits_kept_R4 : assert ($countones(slot_o) == $countones(samp_i[RES_BITS-1:0]))
        else $error("slot ones differ from kept sample bits");
    end
  end

endmodule

// File: rtl/jtx_frame_packer.sv
module jtx_frame_packer
  import jtx_pkg::*;
#(
  parameter int unsigned CONVS     = 2,
  parameter int unsigned RES_BITS  = 14,
  parameter int unsigned SLOT_BITS = 16,
  parameter int unsigned S_PF      = 1,
  parameter int unsigned FPB       = 4,
  localparam int unsigned SPB      = S_PF * FPB,
  localparam int unsigned IN_W     = CONVS * SPB * SAMPLE_W,
  localparam int unsigned SLOTS_PF = CONVS * S_PF,
  localparam int unsigned FRAME_W  = SLOTS_PF * SLOT_BITS,
  localparam int unsigned OUT_W    = FPB * FRAME_W
) (
  input  logic [IN_W-1:0]  samples_i,
  output logic [OUT_W-1:0] frames_o
);

  localparam int unsigned TAIL_W = SLOT_BITS - RES_BITS;

  // frame vector: the first-sent bit is the most significant bit of each frame
  generate
    for (genvar m = 0; m < CONVS; m++) begin : g_conv
      for (genvar k = 0; k < SPB; k++) begin : g_samp
        localparam int unsigned F_IDX = k / S_PF;
        localparam int unsigned S_IDX = k % S_PF;
        localparam int unsigned Q_IDX = m * S_PF + S_IDX;
        localparam int unsigned LO    = F_IDX * FRAME_W + (SLOTS_PF - 1 - Q_IDX) * SLOT_BITS;

        jtx_slot_pad #(
          .RES_BITS  (RES_BITS),
          .SLOT_BITS (SLOT_BITS)
        ) u_pad (
          .samp_i (samples_i[(m*SPB+k)*SAMPLE_W +: SAMPLE_W]),
          .slot_o (frames_o[LO +: SLOT_BITS])
        );

        if (TAIL_W > 0) begin : g_tailchk
          // R4: tail bits at the low end of every slot in the frame stay zero
          always_comb begin
            if (!$isunknown(samples_i)) begin
              assert_tail_zero_R4 : assert (frames_o[LO +: TAIL_W] == '0)
                else $error("nonzero tail bits in frame slot");
            end
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/jtx_lane_dealer.sv
module jtx_lane_dealer
  import jtx_pkg::*;
#(
  parameter int unsigned LANES   = 4,
  parameter int unsigned F_PF    = 1,
  parameter int unsigned FPB     = 4,
  localparam int unsigned FRAME_W = LANES * F_PF * 8,
  localparam int unsigned BUS_W   = FPB * FRAME_W,
  localparam int unsigned LANE_W  = BEAT_OCTETS * 8,
  localparam int unsigned OUT_W   = LANES * LANE_W
) (
  input  logic [BUS_W-1:0] frames_i,
  output logic [OUT_W-1:0] lanes_o
);

  localparam int unsigned OCT_PF = LANES * F_PF;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      for (genvar w = 0; w < BEAT_OCTETS; w++) begin : g_oct
        localparam int unsigned F_IDX = w / F_PF;
        localparam int unsigned I_IDX = w % F_PF;
        localparam int unsigned O_IDX = l * F_PF + I_IDX;
        assign lanes_o[l*LANE_W + w*8 +: 8] =
          frames_i[F_IDX*FRAME_W + (OCT_PF - 1 - O_IDX)*8 +: 8];
      end
    end
  endgenerate

  // R7: the lane deal is a permutation of whole octets, so no bit is lost or doubled
  always_comb begin
    if (!$isunknown(frames_i)) begin
      assert_octets_permuted_R7 : assert ($countones(lanes_o) == $countones(frames_i))
        else $error("lane deal changed the number of set bits");
    end
  end

endmodule

// File: rtl/jtx_transport_framer.sv
module jtx_transport_framer
  import jtx_pkg::*;
#(
  parameter int unsigned LANES     = 4,
  parameter int unsigned CONVS     = 2,
  parameter int unsigned RES_BITS  = 14,
  parameter int unsigned SLOT_BITS = 16,
  localparam int unsigned S_PF     = frame_samples(LANES, CONVS, SLOT_BITS),
  localparam int unsigned F_PF     = frame_octets(LANES, CONVS, SLOT_BITS),
  localparam int unsigned FPB      = BEAT_OCTETS / F_PF,
  localparam int unsigned SPB      = S_PF * FPB,
  localparam int unsigned IN_W     = CONVS * SPB * SAMPLE_W,
  localparam int unsigned OUT_W    = LANES * BEAT_OCTETS * 8
) (
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);

  localparam int unsigned BUS_W = FPB * LANES * F_PF * 8;

  logic [BUS_W-1:0] frame_bus;

  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  jtx_frame_packer #(
    .CONVS     (CONVS),
    .RES_BITS  (RES_BITS),
    .SLOT_BITS (SLOT_BITS),
    .S_PF      (S_PF),
    .FPB       (FPB)
  ) u_packer (
    .samples_i (in_data),
    .frames_o  (frame_bus)
  );

  jtx_lane_dealer #(
    .LANES (LANES),
    .F_PF  (F_PF),
    .FPB   (FPB)
  ) u_dealer (
    .frames_i (frame_bus),
    .lanes_o  (out_data)
  );

  // R9: set bits at the lanes equal set resolution bits at the input
  int ones_in;
  always_comb begin
    ones_in = 0;
    for (int c = 0; c < CONVS * SPB; c++) begin
      ones_in += $countones(in_data[c*SAMPLE_W +: RES_BITS]);
    end
  end

  always_comb begin
    if (!$isunknown(in_data)) begin
      assert_ones_conserved_R9 : assert ($countones(out_data) == ones_in)
        else $error("output set-bit count differs from used input bits");
    end
  end

endmodule

// File: tb/jtx_transport_framer_tb.sv
module jtx_cfg_harness #(
  parameter int unsigned L  = 4,
  parameter int unsigned M  = 2,
  parameter int unsigned N  = 14,
  parameter int unsigned NP = 16
) (
  input  logic clk,
  input  logic go,
  output logic done,
  output int   checks,
  output int   fails
);

  function automatic int unsigned tb_gcd(input int unsigned a, input int unsigned b);
    int unsigned x;
    int unsigned y;
    int unsigned t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  localparam int unsigned G   = tb_gcd(8 * L, M * NP);
  localparam int unsigned S   = 8 * L / G;
  localparam int unsigned F   = M * NP / G;
  localparam int unsigned FPB = 4 / F;
  localparam int unsigned SPB = S * FPB;
  localparam int unsigned IW  = M * SPB * 16;
  localparam int unsigned OW  = L * 32;

  logic          iv;
  logic          ordy;
  logic          ov;
  logic          irdy;
  logic [IW-1:0] din;
  logic [OW-1:0] dout;

  jtx_transport_framer #(
    .LANES     (L),
    .CONVS     (M),
    .RES_BITS  (N),
    .SLOT_BITS (NP)
  ) u_dut (
    .in_valid  (iv),
    .in_ready  (irdy),
    .in_data   (din),
    .out_valid (ov),
    .out_ready (ordy),
    .out_data  (dout)
  );

  // reverse map: for each output bit, find its source bit in the input
  function automatic logic [OW-1:0] model(input logic [IW-1:0] d);
    logic [OW-1:0] r;
    r = '0;
    for (int l = 0; l < int'(L); l++) begin
      for (int w = 0; w < 4; w++) begin
        for (int b = 0; b < 8; b++) begin
          int f, i, o, p, q, j, m, s, k, sb;
          f  = w / F;
          i  = w % F;
          o  = l * F + i;
          p  = o * 8 + (7 - b);
          q  = p / NP;
          j  = p % NP;
          m  = q / S;
          s  = q % S;
          k  = f * S + s;
          sb = NP - 1 - j;
          if (sb >= int'(NP - N)) r[l*32 + w*8 + b] = d[(m*SPB + k)*16 + sb - (NP - N)];
        end
      end
    end
    return r;
  endfunction

  task automatic drive(input logic [IW-1:0] d);
    @(posedge clk);
    #2 din = d;
    @(negedge clk);
  endtask

  task automatic cmp(input string req, input logic [OW-1:0] exp);
    checks++;
    if (dout !== exp) begin
      fails++;
      $display("FAIL %s cfg L=%0d M=%0d NP=%0d: got %h expected %h", req, L, M, NP, dout, exp);
    end
  endtask

  task automatic hs(input logic v, input logic r);
    @(posedge clk);
    #2 iv = v;
    ordy = r;
    @(negedge clk);
    checks++;
    if (ov !== v || irdy !== r) begin
      fails++;
      $display("FAIL R1 cfg L=%0d M=%0d: got valid=%b ready=%b expected valid=%b ready=%b",
               L, M, ov, irdy, v, r);
    end
  endtask

  initial begin
    logic [IW-1:0] d;
    logic [OW-1:0] e;
    done   = 1'b0;
    checks = 0;
    fails  = 0;
    iv     = 1'b0;
    ordy   = 1'b0;
    din    = '0;
    wait (go);

    // R1: handshake passes straight through
    hs(1'b0, 1'b0);
    hs(1'b1, 1'b0);
    hs(1'b0, 1'b1);
    hs(1'b1, 1'b1);

    // R9: zero input gives zero lanes
    drive('0);
    cmp("R9 zero", '0);

    // R2 R6 R7 R8 R9 R10: walking one through every input bit
    for (int n = 0; n < int'(IW); n++) begin
      d = '0;
      d[n] = 1'b1;
      drive(d);
      if (M == 1) cmp("R10 R2 R6 R7 walk", model(d));
      else        cmp("R2 R6 R7 R8 walk", model(d));
    end

    // R3: bits above the resolution have no effect
    if (N < 16) begin
      d = '0;
      for (int c = 0; c < int'(M * SPB); c++) begin
        for (int b = int'(N); b < 16; b++) d[c*16 + b] = 1'b1;
      end
      drive(d);
      cmp("R3 upper bits ignored", '0);
    end

    // R4: all ones leaves exactly the tail bits clear
    d = '1;
    drive(d);
    cmp("R4 all ones", model(d));
    checks++;
    if ($countones(dout) != int'(M * SPB * N)) begin
      fails++;
      $display("FAIL R4 tail count: got %0d expected %0d", $countones(dout), M * SPB * N);
    end

    // R5 R8: hand-computed placement for the 4-lane, 2-converter case
    if (L == 4 && M == 2 && N == 14 && NP == 16) begin
      d = '0;
      d[13:0] = 14'h2ABC;
      drive(d);
      e = '0;
      e[7:0]   = 8'hAA;
      e[39:32] = 8'hF0;
      cmp("R5 R8 hand vector", e);
    end

    // R5 R6 R7: pseudo-random beats
    for (int v = 0; v < 48; v++) begin
      for (int c = 0; c < int'(IW); c += 32) begin
        logic [31:0] rnd;
        rnd = $urandom;
        for (int b = 0; b < 32; b++) if (c + b < int'(IW)) d[c + b] = rnd[b];
      end
      drive(d);
      cmp("R5 R6 R7 random", model(d));
    end

    done = 1'b1;
  end

endmodule

module jtx_transport_framer_tb;

  logic clk;
  logic go;
  logic done_a, done_b, done_c, done_d;
  int   chk_a, chk_b, chk_c, chk_d;
  int   fl_a, fl_b, fl_c, fl_d;
  int   cycles;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // default: S=1 F=1, four frames per beat
  jtx_cfg_harness #(.L(4), .M(2), .N(14), .NP(16)) u_cfg_a (
    .clk(clk), .go(go), .done(done_a), .checks(chk_a), .fails(fl_a));
  // one lane, two converters: S=1 F=4
  jtx_cfg_harness #(.L(1), .M(2), .N(16), .NP(16)) u_cfg_b (
    .clk(clk), .go(go), .done(done_b), .checks(chk_b), .fails(fl_b));
  // one converter, 12-bit slots with tail: S=2 F=1
  jtx_cfg_harness #(.L(3), .M(1), .N(11), .NP(12)) u_cfg_c (
    .clk(clk), .go(go), .done(done_c), .checks(chk_c), .fails(fl_c));
  // two lanes, four converters: S=1 F=4, 12-bit tails in 16-bit slots
  jtx_cfg_harness #(.L(2), .M(4), .N(12), .NP(16)) u_cfg_d (
    .clk(clk), .go(go), .done(done_d), .checks(chk_d), .fails(fl_d));

  initial begin
    int tc;
    int tf;
    go = 1'b0;
    cycles = 0;
    repeat (3) @(posedge clk);
    go = 1'b1;
    while (!(done_a && done_b && done_c && done_d) && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    tc = chk_a + chk_b + chk_c + chk_d;
    tf = fl_a + fl_b + fl_c + fl_d;
    if (!(done_a && done_b && done_c && done_d)) begin
      tc++;
      tf++;
      $display("FAIL watchdog: got timeout after %0d cycles expected completion", cycles);
    end
    $display("TB_RESULT checks=%0d failures=%0d", tc, tf);
    $finish;
  end

endmodule